// File: doc/BRIEF.md
# Workspace Context Switch Sequencer

This block holds the three hardware registers of a processor that keeps its sixteen general registers in memory: the workspace pointer (WP), the program counter (PC) and the status word (ST). General register n is not a flip-flop. It is the memory word at WP plus 2n, in byte addressing. Address bit 0 is always driven as zero.

The block carries out a vectored context switch and the matching return over a word-wide memory port with request/ready handshaking.

- **Switch.** The block reads the new WP from a two-word vector, then reads the new PC from the next word. It then writes the old WP, PC and ST into R13, R14 and R15 of the new workspace. Only after those writes does it commit the new WP and PC. No general register is copied.
- **Return.** The block reads R13, R14 and R15 of the current workspace and loads WP, PC and ST from them together.
- **Single-cycle commands.** Loading WP immediately changes only the pointer and saves nothing. The surrounding core uses a fourth command to set PC and ST.

Top module: `wsContextSeq`

## Requirements
- R1: While `rstN` is low and after its release, `wp`, `pc` and `st` read 0, and `busy` and `memReq` are low.
- R2: Register n of the workspace is the word at byte address WP + 2n. `memAddr[0]` is 0 whenever `memReq` is high. An odd pointer value (from `cmdArg` or from memory) is stored with bit 0 cleared.
- R3: A switch command (`cmdOp`=0, `cmdArg`=vector address V) first reads the word at V, then the word at V+2, with bit 0 of V ignored.
- R4: After the two vector reads, a switch writes the old WP to new WP+26, then the old PC to new WP+28, then the old ST to new WP+30, in that order.
- R5: When a switch completes, `wp` equals the first vector word (bit 0 cleared) and `pc` equals the second. `st` is unchanged.
- R6: A return command (`cmdOp`=1) reads WP+26, WP+28 and WP+30 of the current workspace in that order. At its end it loads `wp`, `pc` and `st` from those three words.
- R7: Command `cmdOp`=2 loads `wp` from `cmdArg` at the next edge, with no memory access and `busy` kept low. Command `cmdOp`=3 loads `pc` from `cmdArg` and `st` from `cmdSt` the same way. Neither command changes any other register.
- R8: `busy` is high from the cycle after an accepted switch or return until the edge that commits the new registers. `wp`, `pc` and `st` do not change while it is high. Commands presented while `busy` is high are ignored.
- R9: Each access holds `memReq`, `memWe`, `memAddr` and `memWdata` until `memReady` is high, so any number of wait states works. No access is made beyond those listed in R3, R4 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, taken when idle |
| cmdOp | input | 2 | 0 switch, 1 return, 2 load WP, 3 load PC and ST |
| cmdArg | input | 16 | Vector address, new WP or new PC |
| cmdSt | input | 16 | New ST for command 3 |
| busy | output | 1 | Switch or return in progress |
| wp | output | 16 | Workspace pointer |
| pc | output | 16 | Program counter |
| st | output | 16 | Status word |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 write, 0 read |
| memAddr | output | 16 | Byte address, bit 0 zero |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, valid with memReady |
| memReady | input | 1 | Completes the current access |

## Verification
The bench uses an odd vector address and an odd stored pointer. A design that forgot the alignment would fetch the wrong vector word or save into misaligned slots. It varies the wait states per access, which exposes a sequencer that advances or changes its address before `memReady`. It issues a load-WP command in the middle of a switch: if that command were accepted, WP would be corrupted or the save slots would shift. It also runs two nested switches followed by two returns with distinct status values, which catches a design that saved or restored the wrong register, used the old base for the save slots, or committed WP before the saves.

// File: rtl/wsCtxPkg.sv
package wsCtxPkg;

  typedef enum logic [1:0] {
    OP_SWITCH = 2'd0,
    OP_RETURN = 2'd1,
    OP_LDWP   = 2'd2,
    OP_LDPCST = 2'd3
  } cmdOp_e;

  typedef enum logic [2:0] {
    SEL_VEC0   = 3'd0,
    SEL_VEC1   = 3'd1,
    SEL_SLOTWP = 3'd2,
    SEL_SLOTPC = 3'd3,
    SEL_SLOTST = 3'd4
  } addrSel_e;

  typedef struct packed {
    logic     latchVec;
    logic     capWp;
    logic     capPc;
    logic     commitSw;
    logic     commitRt;
    logic     loadWp;
    logic     loadPcSt;
    logic     baseNew;
    addrSel_e sel;
  } strobe_t;

endpackage

// File: rtl/wsCtxCtrl.sv
module wsCtxCtrl
  import wsCtxPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       memReady,
  output strobe_t    strb,
  output logic       memReq,
  output logic       memWe,
  output logic       busy
);

  typedef enum logic [3:0] {
    S_IDLE, S_SW_VWP, S_SW_VPC, S_SW_SWP, S_SW_SPC, S_SW_SST,
    S_RT_WP, S_RT_PC, S_RT_ST
  } state_e;

  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb      = '0;
    strb.sel  = SEL_VEC0;
    stateNext = state;
    memReq    = (state != S_IDLE);
    busy      = (state != S_IDLE);
    memWe     = (state == S_SW_SWP) || (state == S_SW_SPC) || (state == S_SW_SST);
    case (state)
      S_IDLE: begin
        if (cmdValid) begin
          case (cmdOp_e'(cmdOp))
            OP_SWITCH: begin strb.latchVec = 1'b1; stateNext = S_SW_VWP; end
            OP_RETURN: stateNext = S_RT_WP;
            OP_LDWP:   strb.loadWp = 1'b1;
            default:   strb.loadPcSt = 1'b1;
          endcase
        end
      end
      S_SW_VWP: begin
        strb.sel = SEL_VEC0;
        if (memReady) begin strb.capWp = 1'b1; stateNext = S_SW_VPC; end
      end
      S_SW_VPC: begin
        strb.sel = SEL_VEC1;
        if (memReady) begin strb.capPc = 1'b1; stateNext = S_SW_SWP; end
      end
      S_SW_SWP: begin
        strb.sel = SEL_SLOTWP; strb.baseNew = 1'b1;
        if (memReady) stateNext = S_SW_SPC;
      end
      S_SW_SPC: begin
        strb.sel = SEL_SLOTPC; strb.baseNew = 1'b1;
        if (memReady) stateNext = S_SW_SST;
      end
      S_SW_SST: begin
        strb.sel = SEL_SLOTST; strb.baseNew = 1'b1;
        if (memReady) begin strb.commitSw = 1'b1; stateNext = S_IDLE; end
      end
      S_RT_WP: begin
        strb.sel = SEL_SLOTWP;
        if (memReady) begin strb.capWp = 1'b1; stateNext = S_RT_PC; end
      end
      S_RT_PC: begin
        strb.sel = SEL_SLOTPC;
        if (memReady) begin strb.capPc = 1'b1; stateNext = S_RT_ST; end
      end
      S_RT_ST: begin
        strb.sel = SEL_SLOTST;
        if (memReady) begin strb.commitRt = 1'b1; stateNext = S_IDLE; end
      end
      default: stateNext = S_IDLE;
    endcase
  end

endmodule

// File: rtl/wsCtxDatapath.sv
module wsCtxDatapath
  import wsCtxPkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int NUM_REGS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [WORD_W-1:0] cmdArg,
  input  logic [WORD_W-1:0] cmdSt,
  input  logic [WORD_W-1:0] memRdata,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [WORD_W-1:0] wp,
  output logic [WORD_W-1:0] pc,
  output logic [WORD_W-1:0] st
);

  localparam int BYTES      = WORD_W / 8;
  localparam int ALIGN_BITS = $clog2(BYTES);
  localparam int SLOT_FIRST = NUM_REGS - 3;
  localparam logic [WORD_W-1:0] ALIGN_MASK = ~WORD_W'((1 << ALIGN_BITS) - 1);
  localparam logic [WORD_W-1:0] WORD_STEP  = WORD_W'(BYTES);

  logic [WORD_W-1:0] wpQ, pcQ, stQ, vecQ, tmpWp, tmpPc;
  logic [WORD_W-1:0] slotBase, rawAddr;
  logic [WORD_W-1:0] slotAddr [3];

  assign slotBase = strb.baseNew ? tmpWp : wpQ;

  for (genvar k = 0; k < 3; k++) begin : g_slot
    assign slotAddr[k] = slotBase + WORD_W'((SLOT_FIRST + k) * BYTES);
  end

  always_comb begin
    case (strb.sel)
      SEL_VEC0:   rawAddr = vecQ;
      SEL_VEC1:   rawAddr = vecQ + WORD_STEP;
      SEL_SLOTWP: rawAddr = slotAddr[0];
      SEL_SLOTPC: rawAddr = slotAddr[1];
      SEL_SLOTST: rawAddr = slotAddr[2];
      default:    rawAddr = vecQ;
    endcase
    case (strb.sel)
      SEL_SLOTWP: memWdata = wpQ;
      SEL_SLOTPC: memWdata = pcQ;
      SEL_SLOTST: memWdata = stQ;
      default:    memWdata = '0;
    endcase
  end

  assign memAddr = rawAddr & ALIGN_MASK;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wpQ   <= '0;
      pcQ   <= '0;
      stQ   <= '0;
      vecQ  <= '0;
      tmpWp <= '0;
      tmpPc <= '0;
    end else begin
      if (strb.latchVec) vecQ <= cmdArg;
      if (strb.capWp)    tmpWp <= memRdata & ALIGN_MASK;
      if (strb.capPc)    tmpPc <= memRdata;
      if (strb.loadWp)   wpQ <= cmdArg & ALIGN_MASK;
      if (strb.loadPcSt) begin
        pcQ <= cmdArg;
        stQ <= cmdSt;
      end
      if (strb.commitSw) begin
        wpQ <= tmpWp;
        pcQ <= tmpPc;
      end
      if (strb.commitRt) begin
        wpQ <= tmpWp;
        pcQ <= tmpPc;
        stQ <= memRdata;
      end
    end
  end

  assign wp = wpQ;
  assign pc = pcQ;
  assign st = stQ;

endmodule

// File: rtl/wsContextSeq.sv
module wsContextSeq
  import wsCtxPkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int NUM_REGS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [WORD_W-1:0] cmdArg,
  input  logic [WORD_W-1:0] cmdSt,
  output logic              busy,
  output logic [WORD_W-1:0] wp,
  output logic [WORD_W-1:0] pc,
  output logic [WORD_W-1:0] st,
  output logic              memReq,
  output logic              memWe,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  input  logic              memReady
);

  strobe_t strb;

  wsCtxCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .memReady (memReady),
    .strb     (strb),
    .memReq   (memReq),
    .memWe    (memWe),
    .busy     (busy)
  );

  wsCtxDatapath #(.WORD_W(WORD_W), .NUM_REGS(NUM_REGS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cmdArg   (cmdArg),
    .cmdSt    (cmdSt),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .wp       (wp),
    .pc       (pc),
    .st       (st)
  );

endmodule

// File: rtl/wsContextSeqChk.sv
module wsContextSeqChk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic [WORD_W-1:0] wp,
  input logic [WORD_W-1:0] pc,
  input logic [WORD_W-1:0] st,
  input logic              memReq,
  input logic              memWe,
  input logic [WORD_W-1:0] memAddr,
  input logic [WORD_W-1:0] memWdata,
  input logic              memReady
);

  p_hold_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata));

  p_even_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr[0] == 1'b0);

  p_first_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> memReq && !memWe);

  p_ctx_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable(wp) && $stable(pc) && $stable(st));

  p_wp_idle_change_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wp) |-> !busy);

endmodule

bind wsContextSeq wsContextSeqChk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busy     (busy),
  .wp       (wp),
  .pc       (pc),
  .st       (st),
  .memReq   (memReq),
  .memWe    (memWe),
  .memAddr  (memAddr),
  .memWdata (memWdata),
  .memReady (memReady)
);

// File: tb/wsContextSeq_bench.sv
module wsContextSeq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'd0;
  logic [15:0] cmdArg = '0;
  logic [15:0] cmdSt = '0;
  logic        busy, memReq, memWe;
  logic [15:0] wp, pc, st, memAddr, memWdata, memRdata;
  logic        memReady = 1'b0;

  always #5 clk = ~clk;

  wsContextSeq u_wsContextSeq (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdArg(cmdArg), .cmdSt(cmdSt), .busy(busy), .wp(wp), .pc(pc), .st(st),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memReady(memReady)
  );

  typedef struct packed {
    logic        we;
    logic [3:0]  req;
    logic [15:0] addr;
    logic [15:0] data;
  } acc_t;

  acc_t        expQ[$];
  logic [15:0] mem [0:255];
  int          total = 0;
  int          bad = 0;
  int          waitLeft = 0;
  int          waitIdx = 0;
  logic [15:0] expWp = '0, expPc = '0, expSt = '0;

  assign memRdata = mem[memAddr[8:1]];

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory model and scoreboard monitor: ready after a varying wait, R9
  always @(negedge clk) begin
    if (!rstN) begin
      memReady = 1'b0;
      waitLeft = 0;
    end else begin
      if (memReady) begin
        memReady = 1'b0;
        waitIdx++;
        waitLeft = (waitIdx * 3) % 5;
      end
      if (memReq && !memReady) begin
        if (waitLeft == 0) begin
          if (expQ.size() == 0) begin
            total++; bad++;
            $display("FAIL R9 unexpected access actual=%h expected=none", memAddr);
          end else begin
            acc_t e;
            e = expQ.pop_front();
            chk($sformatf("R%0d access kind", e.req), {15'd0, memWe}, {15'd0, e.we});
            chk($sformatf("R%0d access address", e.req), memAddr, e.addr);
            if (e.we) chk($sformatf("R%0d write data", e.req), memWdata, e.data);
          end
          if (memWe) mem[memAddr[8:1]] = memWdata;
          memReady = 1'b1;
        end else begin
          waitLeft--;
        end
      end
    end
  end

  task automatic issue(input logic [1:0] op, input logic [15:0] arg, input logic [15:0] sv);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdArg = arg; cmdSt = sv;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic checkRegs(input string tag);
    chk({tag, " wp"}, wp, expWp);
    chk({tag, " pc"}, pc, expPc);
    chk({tag, " st"}, st, expSt);
  endtask

  // R3, R4 expectations for a switch
  task automatic pushSwitch(input logic [15:0] vec);
    logic [15:0] v, nw, np;
    v  = vec & 16'hFFFE;
    nw = mem[v[8:1]] & 16'hFFFE;
    np = mem[(v + 16'd2) >> 1];
    expQ.push_back('{1'b0, 4'd3, v, 16'h0});
    expQ.push_back('{1'b0, 4'd3, v + 16'd2, 16'h0});
    expQ.push_back('{1'b1, 4'd4, nw + 16'd26, expWp});
    expQ.push_back('{1'b1, 4'd4, nw + 16'd28, expPc});
    expQ.push_back('{1'b1, 4'd4, nw + 16'd30, expSt});
    expWp = nw; expPc = np;
  endtask

  // R6 expectations for a return
  task automatic pushReturn();
    logic [15:0] a;
    a = expWp;
    expQ.push_back('{1'b0, 4'd6, a + 16'd26, 16'h0});
    expQ.push_back('{1'b0, 4'd6, a + 16'd28, 16'h0});
    expQ.push_back('{1'b0, 4'd6, a + 16'd30, 16'h0});
    expWp = mem[(a + 16'd26) >> 1] & 16'hFFFE;
    expPc = mem[(a + 16'd28) >> 1];
    expSt = mem[(a + 16'd30) >> 1];
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    mem[8'h08] = 16'h0080; mem[8'h09] = 16'h0200;
    mem[8'h0A] = 16'h00A1; mem[8'h0B] = 16'h0300;

    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {15'd0, busy}, 16'd0);
    chk("R1 memReq in reset", {15'd0, memReq}, 16'd0);
    rstN = 1'b1;
    @(negedge clk);
    checkRegs("R1 after reset");

    // R7: load PC and ST only
    issue(2'd3, 16'h0100, 16'hC00F);
    expPc = 16'h0100; expSt = 16'hC00F;
    chk("R7 busy low", {15'd0, busy}, 16'd0);
    checkRegs("R7 load pc/st");

    // R7, R2: load WP with odd value
    issue(2'd2, 16'h0041, 16'h0);
    expWp = 16'h0040;
    chk("R7 busy low", {15'd0, busy}, 16'd0);
    checkRegs("R2 R7 load wp");
    chk("R7 no access", 16'(expQ.size()), 16'd0);

    // Switch with a command ignored while busy (R8)
    pushSwitch(16'h0010);
    issue(2'd0, 16'h0010, 16'h0);
    chk("R8 busy after start", {15'd0, busy}, 16'd1);
    issue(2'd2, 16'h00F0, 16'h0);
    chk("R8 still busy", {15'd0, busy}, 16'd1);
    waitIdle();
    checkRegs("R5 R8 switch one");
    chk("R4 saved wp", mem[8'h4D], 16'h0040);
    chk("R4 saved st", mem[8'h4F], 16'hC00F);

    issue(2'd3, 16'h0204, 16'h00AA);
    expPc = 16'h0204; expSt = 16'h00AA;
    checkRegs("R7 load pc/st");

    // Odd vector address and odd stored pointer (R2, R3)
    pushSwitch(16'h0015);
    issue(2'd0, 16'h0015, 16'h0);
    waitIdle();
    checkRegs("R2 R3 R5 switch two");
    chk("R5 wp aligned", wp, 16'h00A0);

    issue(2'd3, 16'h0310, 16'h5555);
    expPc = 16'h0310; expSt = 16'h5555;
    checkRegs("R7 wp kept");

    pushReturn();
    issue(2'd1, 16'h0, 16'h0);
    waitIdle();
    checkRegs("R6 return one");
    chk("R6 st restored", st, 16'h00AA);

    pushReturn();
    issue(2'd1, 16'h0, 16'h0);
    waitIdle();
    checkRegs("R6 return two");
    chk("R6 wp restored", wp, 16'h0040);

    repeat (4) @(negedge clk);
    chk("R9 all accesses seen", 16'(expQ.size()), 16'd0);
    finishRun();
  end

endmodule